// File: doc/BRIEF.md
# Phase-Coherent Gated Clock Divider with Single-Step

This block takes one fast base clock and produces four timing taps whose periods are 1, 2, 4 and 8 times the base period. Each tap comes out in two forms. One is an enable pulse one base cycle wide, for logic that stays on the base clock. The other is a gated clock strobe for logic that wants a real edge. A 3-bit phase counter drives all four taps, and every tap fires in the same cycle at the phase-7 boundary. The taps therefore stay coherent in every mode.

A host controls the block through a small register-style port. A write with the run bit set lets the taps run freely. A write with the run bit clear freezes the phase and silences every tap. While the block is halted, each rising edge on the step line advances the phase by one base cycle. Only the taps due in that cycle fire. All state changes on the rising edge of the base clock. A synchronous reset puts the block in halt at phase 0.

The controller has three states. HALT holds the phase. FREE advances it every cycle. TICK advances it for exactly one cycle. The transitions are:
- HALT→FREE on a write with run=1.
- HALT→TICK on a step edge, when no run write comes in the same cycle.
- FREE→HALT on a write with run=0.
- TICK→FREE on a write with run=1.
- TICK→HALT otherwise.
- Any state→HALT on reset.

Top module: `phase_gate_gen`

## Requirements
- R1: The rising edge with rst_sync high leaves the block in HALT at phase 0. After that edge, status_run is 0 and every bit of tap_ena is 0.
- R2: In FREE, tap_ena[0] is 1 in every cycle and status_phase increases by one each cycle, wrapping from 7 to 0.
- R3: Tap bit i (i≥1) is 1 in an advancing cycle exactly when the low i bits of status_phase are all ones. This gives tap 1 a period of 2 cycles, tap 2 a period of 4 and tap 3 a period of 8.
- R4: A slower tap is never 1 unless every faster tap is 1 in the same cycle. When status_phase is 7 in an advancing cycle, all four taps are 1 together.
- R5: A write (host_we=1) with host_run=0 takes effect at the next rising edge. From then on the phase holds its value and tap_ena stays all zeros.
- R6: A write with host_run=1 from HALT restarts the taps from the frozen phase. The first cycle's taps follow the R3 rule for that phase, so no truncated pulse appears.
- R7: In HALT, a 0→1 transition on host_step gives one advancing cycle: the due taps fire once, the phase increments by one, and the block returns to HALT. If host_step stays high, it still counts as one step.
- R8: In FREE, host_step has no effect on phase or taps.
- R9: When a run write and a step edge arrive in the same cycle in HALT, the run write wins and the block enters FREE.
- R10: tap_gclk[i] is high only during the high half of a base cycle, and only when tap_ena[i] was 1 in the preceding base cycle. It is low during every low half.
- R11: status_run is 1 only in FREE, and status_phase always shows the current phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Base clock; all state changes on its rising edge |
| rst_sync | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Control write strobe |
| host_run | input | 1 | Run bit written on host_we (1 = free run, 0 = halt) |
| host_step | input | 1 | Step request level; each rising edge is one step |
| tap_ena | output | NUM_TAPS (4) | Enable pulses; bit i has period 2^i base cycles |
| tap_gclk | output | NUM_TAPS (4) | Glitch-free gated clock strobes matching tap_ena |
| status_run | output | 1 | 1 while the block is in FREE |
| status_phase | output | NUM_TAPS-1 (3) | Current phase counter value |

## Verification
The checker watches several properties on every cycle: taps stay nested, the phase holds whenever tap 0 is low and steps by one whenever it is high, a TICK cycle is followed by silence unless a run write arrives, and a halt write silences the next cycle. Only the bench's scenarios can show the things that depend on host history: a held step request counts once, a step in free run is ignored, a run write beats a simultaneous step, and a restart resumes from the frozen phase. The bench also checks the gated clock strobes at both half-cycles against the previous cycle's enables, which a posedge-sampled property cannot see.

// File: rtl/phase_gate_pkg.sv
package phase_gate_pkg;
    typedef enum logic [1:0] {
        GS_HALT = 2'd0,
        GS_FREE = 2'd1,
        GS_TICK = 2'd2
    } gate_state_e;
endpackage

// File: rtl/pg_step_edge.sv
module pg_step_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/pg_phase_ctr.sv
module pg_phase_ctr #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv_i,
    output logic [CW-1:0] phase_o
);
    always_ff @(posedge clk) begin
        if (rst)        phase_o <= '0;
        else if (adv_i) phase_o <= phase_o + 1'b1;
    end
endmodule

// File: rtl/pg_tap_decode.sv
module pg_tap_decode #(
    parameter int NUM_TAPS = 4,
    localparam int CW = NUM_TAPS - 1
) (
    input  logic                adv_i,
    input  logic [CW-1:0]       phase_i,
    output logic [NUM_TAPS-1:0] ena_o
);
    assign ena_o[0] = adv_i;

    for (genvar i = 1; i < NUM_TAPS; i++) begin : g_tap
        assign ena_o[i] = adv_i & (&phase_i[i-1:0]);
    end
endmodule

// File: rtl/pg_clock_gate.sv
module pg_clock_gate (
    input  logic clk,
    input  logic en_i,
    output logic gclk_o
);
    logic en_low;

    // Enable is captured while the clock is low, so it is steady across the high half.
    always_ff @(negedge clk) begin
        en_low <= en_i;
    end

    assign gclk_o = clk & en_low;
endmodule

// File: rtl/phase_gate_gen.sv
module phase_gate_gen #(
    parameter int NUM_TAPS = 4,
    localparam int CW = NUM_TAPS - 1
) (
    input  logic                clk_base,
    input  logic                rst_sync,
    input  logic                host_we,
    input  logic                host_run,
    input  logic                host_step,
    output logic [NUM_TAPS-1:0] tap_ena,
    output logic [NUM_TAPS-1:0] tap_gclk,
    output logic                status_run,
    output logic [CW-1:0]       status_phase
);
    import phase_gate_pkg::*;

    gate_state_e state_q, state_d;
    logic        step_rise;
    logic        advance;
    logic        run_wr;
    logic        halt_wr;

    assign run_wr  = host_we &  host_run;
    assign halt_wr = host_we & ~host_run;

    pg_step_edge u_edge (
        .clk    (clk_base),
        .rst    (rst_sync),
        .lvl_i  (host_step),
        .rise_o (step_rise)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_HALT: begin
                if (run_wr)         state_d = GS_FREE;
                else if (step_rise) state_d = GS_TICK;
            end
            GS_FREE: begin
                if (halt_wr)        state_d = GS_HALT;
            end
            GS_TICK: begin
                if (run_wr)         state_d = GS_FREE;
                else                state_d = GS_HALT;
            end
            default:                state_d = GS_HALT;
        endcase
    end

    // State register
    always_ff @(posedge clk_base) begin
        if (rst_sync) state_q <= GS_HALT;
        else          state_q <= state_d;
    end

    // Outputs decoded from the current state
    always_comb begin
        advance    = 1'b0;
        status_run = 1'b0;
        unique case (state_q)
            GS_HALT: ;
            GS_FREE: begin
                advance    = 1'b1;
                status_run = 1'b1;
            end
            GS_TICK: advance = 1'b1;
            default: ;
        endcase
    end

    pg_phase_ctr #(.CW(CW)) u_ctr (
        .clk     (clk_base),
        .rst     (rst_sync),
        .adv_i   (advance),
        .phase_o (status_phase)
    );

    pg_tap_decode #(.NUM_TAPS(NUM_TAPS)) u_dec (
        .adv_i   (advance),
        .phase_i (status_phase),
        .ena_o   (tap_ena)
    );

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_gate
        pg_clock_gate u_gate (
            .clk    (clk_base),
            .en_i   (tap_ena[g]),
            .gclk_o (tap_gclk[g])
        );
    end
endmodule

// File: rtl/phase_gate_chk.sv
module phase_gate_chk #(
    parameter int NUM_TAPS = 4,
    localparam int CW = NUM_TAPS - 1
) (
    input logic                clk_base,
    input logic                rst_sync,
    input logic                host_we,
    input logic                host_run,
    input logic [NUM_TAPS-1:0] tap_ena,
    input logic                status_run,
    input logic [CW-1:0]       status_phase
);
    // R1: after a reset edge the block is halted at phase 0
    a_r1_reset_halt: assert property (@(posedge clk_base)
        rst_sync |=> (!status_run && status_phase == '0 && tap_ena == '0));

    // R2: an advancing cycle moves the phase by exactly one
    a_r2_phase_step: assert property (@(posedge clk_base) disable iff (rst_sync)
        tap_ena[0] |=> status_phase == CW'($past(status_phase) + 1'b1));

    // R3: the slowest tap fires only at the last phase
    a_r3_top_at_wrap: assert property (@(posedge clk_base) disable iff (rst_sync)
        tap_ena[NUM_TAPS-1] |-> (&status_phase));

    // R4: taps are nested
    for (genvar i = 1; i < NUM_TAPS; i++) begin : g_nest
        a_r4_nested: assert property (@(posedge clk_base) disable iff (rst_sync)
            tap_ena[i] |-> tap_ena[i-1]);
    end

    // R5: a halt write in free run silences the next cycle; a silent cycle holds the phase
    a_r5_halt_write: assert property (@(posedge clk_base) disable iff (rst_sync)
        (status_run && host_we && !host_run) |=> (tap_ena == '0));
    a_r5_frozen: assert property (@(posedge clk_base) disable iff (rst_sync)
        !tap_ena[0] |=> $stable(status_phase));

    // R7: a single step lasts one cycle unless a run write arrives
    a_r7_single_tick: assert property (@(posedge clk_base) disable iff (rst_sync)
        (tap_ena[0] && !status_run && !(host_we && host_run)) |=> !tap_ena[0]);

    // R11: free-run status implies the base tap is active
    a_r11_run_status: assert property (@(posedge clk_base) disable iff (rst_sync)
        status_run |-> tap_ena[0]);
endmodule

bind phase_gate_gen phase_gate_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
    .clk_base     (clk_base),
    .rst_sync     (rst_sync),
    .host_we      (host_we),
    .host_run     (host_run),
    .tap_ena      (tap_ena),
    .status_run   (status_run),
    .status_phase (status_phase)
);

// File: tb/sim_phase_gate_gen.sv
module sim_phase_gate_gen;
    localparam int NT = 4;
    localparam int PW = NT - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we = 1'b0;
    logic          run = 1'b0;
    logic          step = 1'b0;
    logic [NT-1:0] ena;
    logic [NT-1:0] gclk;
    logic          srun;
    logic [PW-1:0] sphase;

    phase_gate_gen #(.NUM_TAPS(NT)) u0 (
        .clk_base     (clk),
        .rst_sync     (rst),
        .host_we      (we),
        .host_run     (run),
        .host_step    (step),
        .tap_ena      (ena),
        .tap_gclk     (gclk),
        .status_run   (srun),
        .status_phase (sphase)
    );

    always #10 clk = ~clk;

    // Behavioural reference: 0 halt, 1 free, 2 tick
    int    m_st = 0;
    int    m_ph = 0;
    int    m_sq = 0;
    int    m_prev_ena = 0;
    int    n_checks = 0;
    int    n_fail = 0;
    int    n_edges = 0;
    string cur_req = "R1";

    function automatic int exp_ena(int st, int ph);
        int v = 0;
        if (st != 0) begin
            for (int i = 0; i < NT; i++) begin
                int msk = (1 << i) - 1;
                if ((ph & msk) == msk) v |= (1 << i);
            end
        end
        return v;
    endfunction

    always @(posedge clk) begin
        int edge_seen;
        n_edges++;
        m_prev_ena = exp_ena(m_st, m_ph);
        if (rst) begin
            m_st = 0; m_ph = 0; m_sq = 0;
        end else begin
            edge_seen = (step && m_sq == 0) ? 1 : 0;
            m_sq = step ? 1 : 0;
            if (m_st != 0) m_ph = (m_ph + 1) % (1 << PW);
            case (m_st)
                0: if (we && run) m_st = 1; else if (edge_seen != 0) m_st = 2;
                1: if (we && !run) m_st = 0;
                default: m_st = (we && run) ? 1 : 0;
            endcase
        end
    end

    task automatic check(string what, int act, int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, expv, $time);
        end
    endtask

    // Compare in the middle of each half cycle
    always @(posedge clk) begin
        if (n_edges >= 2) begin
            #5;
            check("tap_ena", int'(ena), exp_ena(m_st, m_ph));
            check("status_run", int'(srun), (m_st == 1) ? 1 : 0);
            check("status_phase", int'(sphase), m_ph);
            check("R10 gclk high half", int'(gclk), m_prev_ena);
            #10;
            check("R10 gclk low half", int'(gclk), 0);
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_run(logic b);
        @(negedge clk); we = 1'b1; run = b;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cur_req = "R1";
        cycles(3);
        rst = 1'b0;
        cycles(4);

        cur_req = "R2";
        write_run(1'b1);
        cycles(10);
        cur_req = "R3";
        cycles(16);
        cur_req = "R4";
        cycles(8);

        cur_req = "R5";
        while (sphase != 3'd4) @(negedge clk);
        write_run(1'b0);
        cycles(6);

        cur_req = "R7";
        step = 1'b1; cycles(1); step = 1'b0; cycles(3);
        step = 1'b1; cycles(6); step = 1'b0; cycles(3);
        for (int k = 0; k < 8; k++) begin
            step = ~step; cycles(1);
        end
        step = 1'b0; cycles(3);

        cur_req = "R6";
        write_run(1'b1);
        cycles(9);

        cur_req = "R8";
        for (int k = 0; k < 10; k++) begin
            step = ~step; cycles(1);
        end
        step = 1'b0; cycles(2);

        cur_req = "R9";
        write_run(1'b0);
        cycles(2);
        @(negedge clk); we = 1'b1; run = 1'b1; step = 1'b1;
        @(negedge clk); we = 1'b0; step = 1'b0;
        cycles(5);

        cur_req = "R10";
        cycles(8);

        cur_req = "R11";
        write_run(1'b0);
        cycles(3);
        write_run(1'b1);
        cycles(3);
        rst = 1'b1; cycles(1); rst = 1'b0;
        cycles(4);

        finish_run();
    end
endmodule